// File: doc/BRIEF.md
# SD Command Load Arbiter

This block sits at the front of a card command path and decides, cycle by cycle, whether anything should be loaded into the command registers and where it comes from. Three requesters compete for the load. The first is a host command, held as a level by the start-command bit of the register interface. The second is a stop command that the data path raises as a one-cycle pulse when a transfer ends. The third is a send-interrupt-response request, which only counts while the command path is waiting for an interrupt response from the card.

A host request carries two qualifiers. The clock-only qualifier turns the load into an update of the clock enable, divider and source registers, and no command goes to the card. The wait-previous qualifier holds a real command back while a transfer of known length is running. An open-ended transfer, signalled by a zero byte count, does not hold the command back. Every accepted load is shown as a one-cycle registered strobe together with a source code. A host load also returns a one-cycle clear for the start-command bit. After any load, the arbiter stays quiet for a fixed hold-off window before it accepts another.

Top module: `sd_cmd_load_arb`

## Requirements
- R1: While `rst` is high on a clock edge, every output is 0 after that edge, and both the stop and the interrupt-response pending flags are cleared.
- R2: A host request with `host_clk_only`=0 that is granted on an edge gives, after that same edge, a one-cycle `cmd_load`, `load_src`=2'b01 and a one-cycle `start_clr`.
- R3: A granted host request with `host_clk_only`=1 gives a one-cycle `clk_load` with `load_src`=2'b01 and `start_clr`, and no `cmd_load`. It is never deferred by a running transfer.
- R4: With `host_wait_prev`=0, a host command is granted on the first edge where `cmd_idle`=1, even while a transfer of known length is active.
- R5: With `host_wait_prev`=1, a host command is granted at once if `xfer_active`=0, or if `xfer_active`=1 and `xfer_open`=1 (open-ended transfer).
- R6: With `host_wait_prev`=1, `xfer_active`=1 and `xfer_open`=0, no host command load occurs. The load follows on the first edge after `xfer_active` returns to 0.
- R7: An `autostop_req` pulse is latched as pending. It is granted when `cmd_idle`=1 and gives `cmd_load` with `load_src`=2'b10. A pulse that arrives on the same edge as a stop grant is kept.
- R8: `irq_req` is latched only while `wait_irq`=1, and a pending request is dropped whenever `wait_irq`=0. A grant needs `wait_irq`=1 but not `cmd_idle`. It gives `cmd_load`, `load_src`=2'b11 and `rca_zero`=1, which selects card address 0x000.
- R9: When several requests are eligible on the same edge, the fixed order is stop first, then interrupt response, then host.
- R10: After a grant, no grant occurs on the next `HOLD_CYC` edges. With a request eligible throughout, the next strobe appears exactly `HOLD_CYC`+1 cycles after the previous one.
- R11: Each accepted request produces exactly one strobe and clears its own pending flag. `load_src` is 2'b00 in every cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_start | input | 1 | Start-command bit from the register interface (level) |
| host_clk_only | input | 1 | Host request updates only the clock registers |
| host_wait_prev | input | 1 | Hold the host command while a fixed-length transfer runs |
| autostop_req | input | 1 | One-cycle pulse from the data path at end of transfer |
| irq_req | input | 1 | Send-interrupt-response request pulse |
| wait_irq | input | 1 | Command path is waiting for an interrupt response |
| cmd_idle | input | 1 | Command path can take a new command |
| xfer_active | input | 1 | A data transfer is in progress |
| xfer_open | input | 1 | The active transfer is open-ended (byte count 0) |
| cmd_load | output | 1 | Load strobe for the command, argument and timeout registers |
| clk_load | output | 1 | Load strobe for the clock enable, divider and source registers |
| load_src | output | 2 | Source of this load: 00 none, 01 host, 10 stop, 11 interrupt response |
| start_clr | output | 1 | Clears the host start-command bit |
| rca_zero | output | 1 | The loaded command uses card address 0x000 |

## Verification
The assertions assume a few things about the inputs. `host_clk_only` and `host_wait_prev` hold still while `host_start` is high. `host_start` drops by the cycle after `start_clr`. `autostop_req` and `irq_req` are pulses rather than held levels. The stimulus keeps to these rules. It only sets the qualifiers together with a fresh start bit, clears the start bit on the negedge where `start_clr` is seen, and draws the two request inputs as independent single-cycle events. The transfer and wait flags change rarely, so that deferral and dropping windows last several cycles.

// File: rtl/sd_ld_pkg.sv
package sd_ld_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_HOST = 2'b01,
    SRC_STOP = 2'b10,
    SRC_IRQ  = 2'b11
  } ld_src_e;

  localparam int NUM_QUEUED = 2;
  localparam int QI_STOP    = 0;
  localparam int QI_IRQ     = 1;

endpackage

// File: rtl/sd_ld_flags.sv
module sd_ld_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] take_i,
  input  logic [N-1:0] keep_i,
  output logic [N-1:0] pend_o
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic pend_q;

    // A new request wins over a grant taken in the same cycle;
    // dropping the keep condition discards the request entirely.
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q <= 1'b0;
      end else begin
        pend_q <= keep_i[g] & (set_i[g] | (pend_q & ~take_i[g]));
      end
    end

    assign pend_o[g] = pend_q;
  end

endmodule

// File: rtl/sd_ld_host_gate.sv
module sd_ld_host_gate (
  input  logic host_start,
  input  logic host_clk_only,
  input  logic host_wait_prev,
  input  logic cmd_idle,
  input  logic xfer_active,
  input  logic xfer_open,
  output logic host_ok,
  output logic host_is_clk
);

  logic xfer_clear;
  logic defer;

  always_comb begin
    // A transfer blocks only when its length is fixed.
    xfer_clear  = ~xfer_active | xfer_open;
    // Only real command loads honour the wait-previous qualifier.
    defer       = host_wait_prev & ~host_clk_only & ~xfer_clear;
    host_ok     = host_start & cmd_idle & ~defer;
    host_is_clk = host_clk_only;
  end

endmodule

// File: rtl/sd_ld_holdoff.sv
module sd_ld_holdoff #(
  parameter int HOLD_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  output logic ready_o
);

  localparam int CW = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (fire_i) begin
      cnt_q <= HOLD_V;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready_o = (cnt_q == '0);

endmodule

// File: rtl/sd_cmd_load_arb.sv
module sd_cmd_load_arb
  import sd_ld_pkg::*;
#(
  parameter int HOLD_CYC = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_start,
  input  logic       host_clk_only,
  input  logic       host_wait_prev,
  input  logic       autostop_req,
  input  logic       irq_req,
  input  logic       wait_irq,
  input  logic       cmd_idle,
  input  logic       xfer_active,
  input  logic       xfer_open,
  output logic       cmd_load,
  output logic       clk_load,
  output logic [1:0] load_src,
  output logic       start_clr,
  output logic       rca_zero
);

  logic [NUM_QUEUED-1:0] q_set, q_take, q_keep, q_pend;
  logic    host_ok, host_is_clk, hold_ready;
  ld_src_e grant;

  always_comb begin
    q_set           = '0;
    q_keep          = '1;
    q_set[QI_STOP]  = autostop_req;
    q_set[QI_IRQ]   = irq_req;
    q_keep[QI_IRQ]  = wait_irq;
  end

  sd_ld_flags #(.N(NUM_QUEUED)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_i  (q_set),
    .take_i (q_take),
    .keep_i (q_keep),
    .pend_o (q_pend)
  );

  sd_ld_host_gate u_gate (
    .host_start     (host_start),
    .host_clk_only  (host_clk_only),
    .host_wait_prev (host_wait_prev),
    .cmd_idle       (cmd_idle),
    .xfer_active    (xfer_active),
    .xfer_open      (xfer_open),
    .host_ok        (host_ok),
    .host_is_clk    (host_is_clk)
  );

  sd_ld_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .fire_i  (grant != SRC_NONE),
    .ready_o (hold_ready)
  );

  // Fixed priority: stop, then interrupt response, then host.
  always_comb begin
    grant = SRC_NONE;
    if (hold_ready) begin
      if (q_pend[QI_STOP] && cmd_idle)     grant = SRC_STOP;
      else if (q_pend[QI_IRQ] && wait_irq) grant = SRC_IRQ;
      else if (host_ok)                    grant = SRC_HOST;
    end
    q_take          = '0;
    q_take[QI_STOP] = (grant == SRC_STOP);
    q_take[QI_IRQ]  = (grant == SRC_IRQ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_load  <= 1'b0;
      clk_load  <= 1'b0;
      load_src  <= SRC_NONE;
      start_clr <= 1'b0;
      rca_zero  <= 1'b0;
    end else begin
      cmd_load  <= (grant != SRC_NONE) && !(grant == SRC_HOST && host_is_clk);
      clk_load  <= (grant == SRC_HOST) && host_is_clk;
      load_src  <= grant;
      start_clr <= (grant == SRC_HOST);
      rca_zero  <= (grant == SRC_IRQ);
    end
  end

endmodule

// File: rtl/sd_ld_chk.sv
module sd_ld_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_wait_prev,
  input logic       wait_irq,
  input logic       cmd_idle,
  input logic       xfer_active,
  input logic       xfer_open,
  input logic       cmd_load,
  input logic       clk_load,
  input logic [1:0] load_src,
  input logic       start_clr,
  input logic       rca_zero
);

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(cmd_load && clk_load));

  p_clk_host_r3: assert property (@(posedge clk) disable iff (rst)
    clk_load |-> (load_src == 2'b01 && start_clr));

  p_host_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_load && load_src == 2'b01) |-> start_clr);

  p_defer_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_load && load_src == 2'b01) |->
      $past(!host_wait_prev || !xfer_active || xfer_open));

  p_stop_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (load_src == 2'b10) |-> (cmd_load && $past(cmd_idle)));

  p_irq_window_r8: assert property (@(posedge clk) disable iff (rst)
    (load_src == 2'b11) |-> $past(wait_irq));

  p_rca_r8: assert property (@(posedge clk) disable iff (rst)
    rca_zero |-> (load_src == 2'b11 && cmd_load));

  p_gap_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_load || clk_load) |=> !(cmd_load || clk_load));

  p_src_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    (load_src != 2'b00) |-> (cmd_load || clk_load));

endmodule

bind sd_cmd_load_arb sd_ld_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .host_wait_prev (host_wait_prev),
  .wait_irq       (wait_irq),
  .cmd_idle       (cmd_idle),
  .xfer_active    (xfer_active),
  .xfer_open      (xfer_open),
  .cmd_load       (cmd_load),
  .clk_load       (clk_load),
  .load_src       (load_src),
  .start_clr      (start_clr),
  .rca_zero       (rca_zero)
);

// File: tb/sim_sd_cmd_load_arb.sv
module sim_sd_cmd_load_arb;

  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_start = 0, host_clk_only = 0, host_wait_prev = 0;
  logic autostop_req = 0, irq_req = 0, wait_irq = 0, cmd_idle = 0;
  logic xfer_active = 0, xfer_open = 0;
  logic cmd_load, clk_load, start_clr, rca_zero;
  logic [1:0] load_src;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sd_cmd_load_arb #(.HOLD_CYC(HOLD)) u0 (
    .clk, .rst, .host_start, .host_clk_only, .host_wait_prev,
    .autostop_req, .irq_req, .wait_irq, .cmd_idle, .xfer_active,
    .xfer_open, .cmd_load, .clk_load, .load_src, .start_clr, .rca_zero
  );

  // Reference model built from the requirements.
  bit m_stop, m_irq;
  int m_cnt;
  bit e_cmd, e_clk, e_clr, e_rca;
  logic [1:0] e_src;

  function automatic logic [1:0] pick(bit stop, bit irq, int cnt);
    if (cnt != 0) return 2'b00;
    if (stop && cmd_idle) return 2'b10;
    if (irq && wait_irq) return 2'b11;
    if (host_start && cmd_idle &&
        (host_clk_only || !host_wait_prev || !xfer_active || xfer_open))
      return 2'b01;
    return 2'b00;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_stop = 0; m_irq = 0; m_cnt = 0;
      e_cmd = 0; e_clk = 0; e_clr = 0; e_rca = 0; e_src = 0;
    end else begin
      logic [1:0] g;
      g = pick(m_stop, m_irq, m_cnt);
      e_src = g;
      e_cmd = (g != 0) && !(g == 2'b01 && host_clk_only);
      e_clk = (g == 2'b01) && host_clk_only;
      e_clr = (g == 2'b01);
      e_rca = (g == 2'b11);
      m_stop = autostop_req | (m_stop & (g != 2'b10));
      m_irq  = wait_irq & (irq_req | (m_irq & (g != 2'b11)));
      m_cnt  = (g != 0) ? HOLD : ((m_cnt != 0) ? m_cnt - 1 : 0);
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(logic [1:0] s, bit c);
    case (s)
      2'b01:   return c ? "R3" : "R2";
      2'b10:   return "R7";
      2'b11:   return "R8";
      default: return "R11";
    endcase
  endfunction

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      logic [5:0] a, e;
      a = {cmd_load, clk_load, load_src, start_clr, rca_zero};
      e = {e_cmd, e_clk, e_src, e_clr, e_rca};
      chk(a == e, tag_of(e_src, e_clk), int'(a), int'(e));
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Next negedge; the host register clears its start bit on start_clr.
  task automatic nx();
    @(negedge clk);
    if (start_clr) host_start = 0;
  endtask

  task automatic settle();
    repeat (HOLD + 3) nx();
  endtask

  task automatic wait_load(output int n);
    n = 0;
    do begin nx(); n++; end while (!(cmd_load || clk_load) && n < 40);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    cmp_on = 1;
    // R1: reset state
    chk({cmd_load, clk_load, load_src, start_clr, rca_zero} == 0, "R1",
        int'({cmd_load, clk_load, load_src, start_clr, rca_zero}), 0);
    rst = 0; cmd_idle = 1;
    nx();
    chk(!cmd_load, "R1", cmd_load, 0);

    // R2: plain host command
    host_start = 1;
    nx();
    chk(cmd_load && load_src == 2'b01 && start_clr, "R2", int'(load_src), 1);
    nx();
    chk(!cmd_load && !start_clr, "R2", cmd_load, 0);
    settle();

    // R3: clock-only update, even during fixed-length transfer
    xfer_active = 1; host_wait_prev = 1; host_clk_only = 1; host_start = 1;
    nx();
    chk(clk_load && !cmd_load && load_src == 2'b01, "R3", clk_load, 1);
    host_clk_only = 0;
    settle();

    // R6: deferred while fixed-length transfer runs
    host_start = 1;
    repeat (5) begin
      nx();
      chk(!cmd_load, "R6", cmd_load, 0);
    end
    xfer_active = 0;
    nx();
    chk(cmd_load && load_src == 2'b01, "R6", cmd_load, 1);
    settle();

    // R5: open-ended transfer does not defer
    xfer_active = 1; xfer_open = 1; host_start = 1;
    nx();
    chk(cmd_load, "R5", cmd_load, 1);
    settle();

    // R4: wait-previous clear loads during fixed-length transfer
    xfer_open = 0; host_wait_prev = 0; host_start = 1;
    nx();
    chk(cmd_load, "R4", cmd_load, 1);
    xfer_active = 0;

    // R10: exact hold-off gap with a request held eligible
    host_start = 1;
    wait_load(n);
    chk(n == HOLD + 1, "R10", n, HOLD + 1);
    settle();

    // R9: stop beats host, then interrupt response beats host
    cmd_idle = 0; autostop_req = 1; host_start = 1;
    nx(); autostop_req = 0;
    nx();
    chk(!cmd_load, "R7", cmd_load, 0);
    cmd_idle = 1;
    nx();
    chk(cmd_load && load_src == 2'b10, "R9", int'(load_src), 2);
    wait_irq = 1; irq_req = 1;
    nx(); irq_req = 0;
    wait_load(n);
    chk(load_src == 2'b11 && rca_zero, "R9", int'(load_src), 3);
    wait_load(n);
    chk(load_src == 2'b01, "R9", int'(load_src), 1);
    settle();

    // R8: request dropped when the wait window closes
    cmd_idle = 0; host_start = 1; wait_irq = 1;
    nx();
    chk(!cmd_load, "R8", cmd_load, 0);
    irq_req = 1; wait_irq = 0;
    nx(); irq_req = 0; wait_irq = 1;
    repeat (4) begin
      nx();
      chk(!cmd_load, "R8", cmd_load, 0);
    end
    wait_irq = 0; cmd_idle = 1;
    settle();

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      nx();
      autostop_req = ($urandom % 20) == 0;
      irq_req      = ($urandom % 10) == 0;
      cmd_idle     = ($urandom % 6) != 0;
      if (($urandom % 30) == 0) wait_irq = ~wait_irq;
      if (($urandom % 25) == 0) begin
        xfer_active = ~xfer_active;
        xfer_open   = $urandom % 3 == 0;
      end
      if (!host_start && !start_clr && ($urandom % 4) == 0) begin
        host_start     = 1;
        host_clk_only  = ($urandom % 4) == 0;
        host_wait_prev = $urandom % 2;
      end
    end
    autostop_req = 0; irq_req = 0;
    repeat (3) nx();
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
  end

endmodule